// File: doc/BRIEF.md
# In-Order Scoreboard Issue Controller

This block is the issue gate of a single-issue, in-order pipeline that has no operand bypass network. Each cycle the decode stage presents at most one decoded instruction: an operation class, an optional destination register and up to two optional source registers. The block decides in the same cycle whether that instruction may start execution. When it may not, the decode stage keeps the same instruction on its outputs and presents it again the next cycle.

The block keeps one pending bit per architectural register and a reservation line for the shared result-write port. The line has one slot per future cycle, up to the longest unit latency. The execution units are pipelined, so the only structural conflict between units is the single write-back port. Every issued instruction that writes a register books that port for the cycle it completes. When that cycle arrives, the block announces a write-back event naming the register. Unit latencies are parameters.

Top module: `sb_issue_ctl`

## Requirements
- R1: At most one instruction issues per cycle, in program order. `issue` is high only when `dec_valid` is high. `stall` equals `dec_valid` and not `issue`. While `rst` is high nothing issues.
- R2: An instruction with an enabled source whose register is pending may not issue. It may issue no earlier than the cycle after that producer's write-back cycle, because there is no bypass.
- R3: The class code sets the latency: 0 = integer (1 cycle), 1 = load/store unit (2 cycles), 2 = FP add (2 cycles), 3 = FP multiply (4 cycles). An instruction issued in cycle t with latency L and an enabled destination raises `wb_valid` with `wb_reg` equal to its destination in cycle t+L, and in no other cycle.
- R4: Only one write-back can happen per cycle. An instruction whose write-back cycle is already reserved stalls until a later issue cycle lands on a free slot.
- R5: An instruction whose enabled destination is still pending for an older instruction stalls. It may issue no earlier than the cycle after that older write-back.
- R6: An instruction with its destination disabled, such as a store, reserves no write-back slot, marks no register pending and produces no write-back event.
- R7: A synchronous active-high reset clears every pending bit and every reservation. After reset no write-back event occurs until a new instruction issues, and every register is free.
- R8: A source whose enable is low is ignored, even if its register number names a pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_cls | input | 2 | Operation class code (sets latency) |
| dec_dst | input | RW | Destination register number |
| dec_dst_en | input | 1 | Instruction writes `dec_dst` |
| dec_src1 | input | RW | First source register number |
| dec_src1_en | input | 1 | First source is read |
| dec_src2 | input | RW | Second source register number |
| dec_src2_en | input | 1 | Second source is read |
| issue | output | 1 | Instruction in decode slot enters execution this cycle |
| stall | output | 1 | Instruction present but held this cycle |
| wb_valid | output | 1 | A result is written back this cycle (registered) |
| wb_reg | output | RW | Register written back this cycle (registered) |

## Verification
The bench drives the controller with several short programs:
- A load/multiply/add/store chain exposes the no-bypass read-after-write spacing and each class latency.
- A mixed-latency burst of independent instructions makes a short-latency result land on a cycle already booked by a longer one, which separates port-collision stalls from data stalls.
- Back-to-back writes to one register, and reads that name a busy register through a disabled source, distinguish write-after-write blocking from false dependences.
- A reset issued while reservations are outstanding, followed by an immediate reader of the formerly busy register, shows that the reset discards pending state.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_MEM  = 2'd1,
    CLS_FADD = 2'd2,
    CLS_FMUL = 2'd3
  } op_cls_e;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sb_busy_table.sv
module sb_busy_table #(
  parameter int NREG = 32,
  parameter int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [RW-1:0] set_reg,
  input  logic          clr_en,
  input  logic [RW-1:0] clr_reg,
  input  logic [RW-1:0] q_src1,
  input  logic [RW-1:0] q_src2,
  input  logic [RW-1:0] q_dst,
  output logic          src1_busy,
  output logic          src2_busy,
  output logic          dst_busy
);

  logic [NREG-1:0] busy;

  genvar r;
  generate
    for (r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          busy[r] <= 1'b0;
        end else if (set_en && set_reg == RW'(r)) begin
          busy[r] <= 1'b1;
        end else if (clr_en && clr_reg == RW'(r)) begin
          busy[r] <= 1'b0;
        end
      end
    end
  endgenerate

  assign src1_busy = busy[q_src1];
  assign src2_busy = busy[q_src2];
  assign dst_busy  = busy[q_dst];

  // R3
  clr_busy_chk: assert property (@(posedge clk) disable iff (rst)
    clr_en |-> busy[clr_reg]);

  // R5
  set_free_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |-> !busy[set_reg]);

endmodule

// File: rtl/sb_wb_ring.sv
module sb_wb_ring #(
  parameter int NREG   = 32,
  parameter int RW     = $clog2(NREG),
  parameter int MAXLAT = 4,
  parameter int LW     = $clog2(MAXLAT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] q_lat,
  output logic          q_conflict,
  input  logic          ins_en,
  input  logic [RW-1:0] ins_reg,
  output logic          wb_valid,
  output logic [RW-1:0] wb_reg
);

  logic [MAXLAT-1:0] vld;
  logic [RW-1:0]     rg [MAXLAT];

  genvar j;
  generate
    for (j = 0; j < MAXLAT; j++) begin : g_slot
      logic          nxt_v;
      logic [RW-1:0] nxt_r;
      if (j == MAXLAT - 1) begin : g_top
        assign nxt_v = 1'b0;
        assign nxt_r = '0;
      end else begin : g_mid
        assign nxt_v = vld[j+1];
        assign nxt_r = rg[j+1];
      end
      always_ff @(posedge clk) begin
        if (rst) begin
          vld[j] <= 1'b0;
          rg[j]  <= '0;
        end else if (ins_en && q_lat == LW'(j + 1)) begin
          vld[j] <= 1'b1;
          rg[j]  <= ins_reg;
        end else begin
          vld[j] <= nxt_v;
          rg[j]  <= nxt_r;
        end
      end
    end
  endgenerate

  always_comb begin
    q_conflict = 1'b0;
    for (int k = 1; k < MAXLAT; k++) begin
      if (q_lat == LW'(k)) q_conflict = vld[k];
    end
  end

  assign wb_valid = vld[0];
  assign wb_reg   = rg[0];

endmodule

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl #(
  parameter int NREG     = 32,
  parameter int LAT_INT  = 1,
  parameter int LAT_MEM  = 2,
  parameter int LAT_FADD = 2,
  parameter int LAT_FMUL = 4,
  parameter int RW       = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_valid,
  input  logic [1:0]    dec_cls,
  input  logic [RW-1:0] dec_dst,
  input  logic          dec_dst_en,
  input  logic [RW-1:0] dec_src1,
  input  logic          dec_src1_en,
  input  logic [RW-1:0] dec_src2,
  input  logic          dec_src2_en,
  output logic          issue,
  output logic          stall,
  output logic          wb_valid,
  output logic [RW-1:0] wb_reg
);
  import sb_pkg::*;

  localparam int MAXLAT = max_of4(LAT_INT, LAT_MEM, LAT_FADD, LAT_FMUL);
  localparam int LW     = $clog2(MAXLAT + 1);

  logic [LW-1:0] lat;
  logic          s1_busy, s2_busy, d_busy, port_clash;
  logic          raw_hold, waw_hold, wb_hold;
  logic          book;

  always_comb begin
    case (op_cls_e'(dec_cls))
      CLS_INT:  lat = LW'(LAT_INT);
      CLS_MEM:  lat = LW'(LAT_MEM);
      CLS_FADD: lat = LW'(LAT_FADD);
      default:  lat = LW'(LAT_FMUL);
    endcase
  end

  sb_busy_table #(.NREG(NREG), .RW(RW)) u_busy (
    .clk       (clk),
    .rst       (rst),
    .set_en    (book),
    .set_reg   (dec_dst),
    .clr_en    (wb_valid),
    .clr_reg   (wb_reg),
    .q_src1    (dec_src1),
    .q_src2    (dec_src2),
    .q_dst     (dec_dst),
    .src1_busy (s1_busy),
    .src2_busy (s2_busy),
    .dst_busy  (d_busy)
  );

  sb_wb_ring #(.NREG(NREG), .RW(RW), .MAXLAT(MAXLAT), .LW(LW)) u_ring (
    .clk        (clk),
    .rst        (rst),
    .q_lat      (lat),
    .q_conflict (port_clash),
    .ins_en     (book),
    .ins_reg    (dec_dst),
    .wb_valid   (wb_valid),
    .wb_reg     (wb_reg)
  );

  assign raw_hold = (dec_src1_en && s1_busy) || (dec_src2_en && s2_busy);
  assign waw_hold = dec_dst_en && d_busy;
  assign wb_hold  = dec_dst_en && port_clash;
  assign issue    = dec_valid && !rst && !raw_hold && !waw_hold && !wb_hold;
  assign stall    = dec_valid && !issue;
  assign book     = issue && dec_dst_en;

  // R5
  waw_vs_retire_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && dec_dst_en && wb_valid) |-> (dec_dst != wb_reg));

  // R2
  raw_src1_nobyp_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && dec_src1_en && wb_valid) |-> (dec_src1 != wb_reg));

  // R2
  raw_src2_nobyp_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && dec_src2_en && wb_valid) |-> (dec_src2 != wb_reg));

endmodule

// File: tb/tb_sb_issue_ctl.sv
module tb_sb_issue_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;
  localparam int RW = 5;

  typedef struct {
    bit bub;
    int cls;
    int dst;
    bit den;
    int s1;
    bit s1e;
    int s2;
    bit s2e;
  } ins_t;

  logic clk = 0;
  logic rst = 1;
  logic dec_valid = 0;
  logic [1:0] dec_cls = 0;
  logic [RW-1:0] dec_dst = 0, dec_src1 = 0, dec_src2 = 0;
  logic dec_dst_en = 0, dec_src1_en = 0, dec_src2_en = 0;
  logic issue, stall, wb_valid;
  logic [RW-1:0] wb_reg;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int pend [NREG];
  int wbtab [int];
  ins_t prog [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sb_issue_ctl dut (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_cls(dec_cls),
    .dec_dst(dec_dst), .dec_dst_en(dec_dst_en),
    .dec_src1(dec_src1), .dec_src1_en(dec_src1_en),
    .dec_src2(dec_src2), .dec_src2_en(dec_src2_en),
    .issue(issue), .stall(stall), .wb_valid(wb_valid), .wb_reg(wb_reg)
  );

  function automatic int lat_of(int c);
    case (c)
      0: return 1;
      1: return 2;
      2: return 2;
      default: return 4;
    endcase
  endfunction

  function automatic bit is_busy(int r);
    return pend[r] >= cyc;
  endfunction

  task automatic check(bit ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", what, cyc, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int r = 0; r < NREG; r++) pend[r] = -1;
    wbtab.delete();
  endtask

  task automatic push(bit bub, int cls, int dst, bit den, int s1, bit s1e, int s2, bit s2e);
    ins_t t;
    t.bub = bub; t.cls = cls; t.dst = dst; t.den = den;
    t.s1 = s1; t.s1e = s1e; t.s2 = s2; t.s2e = s2e;
    prog.push_back(t);
  endtask

  task automatic step(input ins_t t, input bit do_rst, output bit iss);
    bit ev, ei;
    int er, l;
    @(negedge clk);
    rst         = do_rst;
    dec_valid   = !t.bub && !do_rst;
    dec_cls     = 2'(t.cls);
    dec_dst     = RW'(t.dst);
    dec_dst_en  = t.den;
    dec_src1    = RW'(t.s1);
    dec_src1_en = t.s1e;
    dec_src2    = RW'(t.s2);
    dec_src2_en = t.s2e;
    #1;
    ev = wbtab.exists(cyc);
    er = ev ? wbtab[cyc] : 0;
    l  = lat_of(t.cls);
    ei = dec_valid && !do_rst;
    if (t.s1e && is_busy(t.s1)) ei = 0;
    if (t.s2e && is_busy(t.s2)) ei = 0;
    if (t.den && is_busy(t.dst)) ei = 0;
    if (t.den && wbtab.exists(cyc + l)) ei = 0;
    check(issue == ei, "issue R1 R2 R4 R5 R8", int'(issue), int'(ei));
    check(stall == (dec_valid && !ei), "stall R1", int'(stall), int'(dec_valid && !ei));
    check(wb_valid == ev, "wb_valid R3 R6 R7", int'(wb_valid), int'(ev));
    if (ev) check(int'(wb_reg) == er, "wb_reg R3", int'(wb_reg), er);
    if (ei && t.den) begin
      pend[t.dst] = cyc + l;
      wbtab[cyc + l] = t.dst;
    end
    if (do_rst) model_clear();
    cyc++;
    iss = ei;
  endtask

  task automatic run_prog();
    int i = 0;
    bit iss;
    ins_t idle;
    idle.bub = 1; idle.cls = 0; idle.dst = 0; idle.den = 0;
    idle.s1 = 0; idle.s1e = 0; idle.s2 = 0; idle.s2e = 0;
    while (i < prog.size()) begin
      step(prog[i], 1'b0, iss);
      if (prog[i].bub || iss) i++;
    end
    for (int k = 0; k < 6; k++) step(idle, 1'b0, iss);
    prog.delete();
  endtask

  initial begin
    bit iss;
    ins_t idle;
    idle.bub = 1; idle.cls = 0; idle.dst = 0; idle.den = 0;
    idle.s1 = 0; idle.s1e = 0; idle.s2 = 0; idle.s2e = 0;
    model_clear();
    // R7: reset state
    step(idle, 1'b1, iss);
    step(idle, 1'b1, iss);
    check(wb_valid == 0, "reset wb_valid R7", int'(wb_valid), 0);

    // Chain: load, load, mul, load, load, mul, add, store (R2 R3 R6)
    push(0, 1, 0, 1, 1, 1, 0, 0);
    push(0, 1, 1, 1, 2, 1, 0, 0);
    push(0, 3, 0, 1, 0, 1, 1, 1);
    push(0, 1, 2, 1, 3, 1, 0, 0);
    push(0, 1, 3, 1, 4, 1, 0, 0);
    push(0, 3, 2, 1, 2, 1, 3, 1);
    push(0, 2, 0, 1, 0, 1, 2, 1);
    push(0, 1, 0, 0, 0, 1, 5, 1);
    run_prog();

    // Port collision: mul, add, load, int burst (R4)
    push(0, 3, 10, 1, 0, 0, 0, 0);
    push(0, 2, 12, 1, 0, 0, 0, 0);
    push(0, 1, 13, 1, 0, 0, 0, 0);
    push(0, 0, 14, 1, 0, 0, 0, 0);
    push(0, 0, 15, 1, 0, 0, 0, 0);
    push(0, 3, 16, 1, 0, 0, 0, 0);
    push(0, 0, 17, 1, 0, 0, 0, 0);
    push(0, 0, 18, 1, 0, 0, 0, 0);
    push(0, 0, 19, 1, 0, 0, 0, 0);
    run_prog();

    // WAW and disabled sources naming busy registers (R5 R8)
    push(0, 3, 5, 1, 0, 0, 0, 0);
    push(0, 0, 6, 1, 5, 0, 5, 0);
    push(0, 0, 5, 1, 0, 0, 0, 0);
    push(1, 0, 0, 0, 0, 0, 0, 0);
    push(0, 2, 7, 1, 5, 0, 5, 1);
    push(0, 1, 0, 0, 7, 1, 0, 0);
    run_prog();

    // Independent integer stream with bubbles (R1)
    for (int k = 0; k < 8; k++) begin
      push(0, 0, 20 + k, 1, k, 1, 31, 1);
      if (k == 3) push(1, 0, 0, 0, 0, 0, 0, 0);
    end
    run_prog();

    // Reset with outstanding reservations (R7)
    push(0, 3, 9, 1, 0, 0, 0, 0);
    push(0, 1, 11, 1, 0, 0, 0, 0);
    run_prog_partial();
    step(idle, 1'b1, iss);
    push(0, 0, 9, 1, 9, 1, 11, 1);
    run_prog();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  task automatic run_prog_partial();
    int i = 0;
    bit iss;
    while (i < prog.size()) begin
      step(prog[i], 1'b0, iss);
      if (prog[i].bub || iss) i++;
    end
    prog.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule